// File: doc/BRIEF.md
# System-instruction access privilege decoder

This block decides what happens when a core issues one particular system instruction. The instruction has two encodings. The plain form invalidates over every attribute. The second form, with CRn one higher, restricts the scope so that accesses carrying the XS attribute are excluded. The decoder takes the five encoding fields and the execution context: the current exception level, a nested-virtualization trap control, the presence of the XS feature, the presence of the instruction itself, whether EL2 is enabled, whether the realm feature is present, and whether the EL1 security state is valid. From these it resolves exactly one of four outcomes. The instruction can be undefined, can trap to EL2 with an exception class, can be a silent no-op, or can execute with a scope selector.

Decode is combinational. The result is captured in a register on a valid strobe, so each outcome flag pulses for one cycle, one cycle after that strobe. The pipeline acts on these flags. Carrying out the invalidation itself is not part of this block.

Top module: `sysop_access_decode`

## Requirements
- R1: An encoding matches the plain form only when op0=0b01, op1=0b100, CRn=0b1000, CRm=0b0010 and op2=0b010. Any other field value raises none of the four outcome flags.
- R2: The XS-excluding form matches the same fields except CRn=0b1001. When it executes, `scope_excl_o`=1. For the plain form, and for every non-execute outcome, `scope_excl_o`=0.
- R3: When `instr_feat_i`=0, both forms decode as undefined at every exception level.
- R4: When `xs_feat_i`=0, the XS-excluding form is undefined at every exception level. The plain form is unaffected by `xs_feat_i`.
- R5: At EL0 (`cur_el_i`=0), both forms are undefined.
- R6: At EL1 (`cur_el_i`=1), if `nest_trap_i`=1 the instruction traps, with `trap_o`=1 and `trap_class_o`=0x18. If `nest_trap_i`=0 it is undefined. `trap_class_o` is 0 whenever `trap_o`=0.
- R7: At EL2 (`cur_el_i`=2), the instruction executes (`exec_o`=1).
- R8: At EL3 (`cur_el_i`=3), the instruction is a no-op when `el2_en_i`=0. It is also a no-op when `realm_feat_i`=1 and `sec_valid_i`=0.
- R9: At EL3, in every other case, the instruction executes with the same scope rule as at EL2.
- R10: At most one of `undef_o`, `trap_o`, `nop_o`, `exec_o` is high. The flags reflect the inputs sampled at the clock edge where `valid_i`=1 and stay valid for the following cycle. After an edge where `valid_i`=0, all flags are low.
- R11: While reset is asserted, and until the first strobe after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Decode strobe |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| cur_el_i | input | 2 | Current exception level, 0 to 3 |
| nest_trap_i | input | 1 | Nested-virtualization trap control |
| xs_feat_i | input | 1 | XS feature present |
| instr_feat_i | input | 1 | Instruction implemented |
| el2_en_i | input | 1 | EL2 enabled |
| realm_feat_i | input | 1 | Realm feature present |
| sec_valid_i | input | 1 | EL1 security state valid |
| undef_o | output | 1 | Outcome: undefined |
| trap_o | output | 1 | Outcome: trap to EL2 |
| trap_class_o | output | 6 | Exception class, valid with trap |
| nop_o | output | 1 | Outcome: no-op |
| exec_o | output | 1 | Outcome: execute |
| scope_excl_o | output | 1 | Execute scope: 1 excludes XS accesses |

## Verification
A fault in the priority order would show up in the cycle after the strobe as the wrong flag. One example is an EL3 no-op reported for the XS-excluding form when XS is absent. A register that holds its state too long would leave a flag high in the idle cycle after a strobe. A register that updates without its enable would raise a flag one cycle too early. Each vector is therefore checked once in the cycle after its strobe and once more in the following idle cycle.

// File: rtl/sysop_pkg.sv
package sysop_pkg;

  localparam int OP0_W   = 2;
  localparam int OP1_W   = 3;
  localparam int CR_W    = 4;
  localparam int OP2_W   = 3;
  localparam int CLASS_W = 6;
  localparam int NFORMS  = 2;

  typedef enum logic [2:0] {
    OUT_NONE  = 3'd0,
    OUT_UNDEF = 3'd1,
    OUT_TRAP  = 3'd2,
    OUT_NOP   = 3'd3,
    OUT_EXEC  = 3'd4
  } outcome_e;

  typedef struct packed {
    outcome_e kind;
    logic     excl;
  } verdict_t;

endpackage

// File: rtl/sysop_enc_match.sv
module sysop_enc_match
  import sysop_pkg::*;
#(
  parameter logic [OP0_W-1:0] OP0_V      = 2'b01,
  parameter logic [OP1_W-1:0] OP1_V      = 3'b100,
  parameter logic [CR_W-1:0]  CRN_PLAIN  = 4'b1000,
  parameter logic [CR_W-1:0]  CRN_EXCL   = 4'b1001,
  parameter logic [CR_W-1:0]  CRM_V      = 4'b0010,
  parameter logic [OP2_W-1:0] OP2_V      = 3'b010
) (
  input  logic [OP0_W-1:0]  op0_i,
  input  logic [OP1_W-1:0]  op1_i,
  input  logic [CR_W-1:0]   crn_i,
  input  logic [CR_W-1:0]   crm_i,
  input  logic [OP2_W-1:0]  op2_i,
  output logic [NFORMS-1:0] hit_o
);

  logic common_hit;

  // fields shared by both forms
  assign common_hit = (op0_i == OP0_V) && (op1_i == OP1_V) &&
                      (crm_i == CRM_V) && (op2_i == OP2_V);

  // bit 0: plain form, bit 1: XS-excluding form
  for (genvar f = 0; f < NFORMS; f++) begin : g_form
    localparam logic [CR_W-1:0] CRN_F = (f == 0) ? CRN_PLAIN : CRN_EXCL;
    assign hit_o[f] = common_hit && (crn_i == CRN_F);
  end

endmodule

// File: rtl/sysop_priv_resolve.sv
module sysop_priv_resolve
  import sysop_pkg::*;
(
  input  logic [NFORMS-1:0] hit_i,
  input  logic [1:0]        cur_el_i,
  input  logic              nest_trap_i,
  input  logic              xs_feat_i,
  input  logic              instr_feat_i,
  input  logic              el2_en_i,
  input  logic              realm_feat_i,
  input  logic              sec_valid_i,
  output verdict_t          verdict_o
);

  logic any_hit;
  logic excl_form;
  logic el3_skip;

  assign any_hit   = |hit_i;
  assign excl_form = hit_i[1];
  assign el3_skip  = !el2_en_i || (realm_feat_i && !sec_valid_i);

  always_comb begin
    verdict_o.kind = OUT_NONE;
    verdict_o.excl = 1'b0;
    if (any_hit) begin
      if (!instr_feat_i || (excl_form && !xs_feat_i)) begin
        verdict_o.kind = OUT_UNDEF;
      end else begin
        unique case (cur_el_i)
          2'd0: verdict_o.kind = OUT_UNDEF;
          2'd1: verdict_o.kind = nest_trap_i ? OUT_TRAP : OUT_UNDEF;
          2'd2: begin
            verdict_o.kind = OUT_EXEC;
            verdict_o.excl = excl_form;
          end
          default: begin
            if (el3_skip) begin
              verdict_o.kind = OUT_NOP;
            end else begin
              verdict_o.kind = OUT_EXEC;
              verdict_o.excl = excl_form;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sysop_out_reg.sv
module sysop_out_reg
  import sysop_pkg::*;
#(
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  verdict_t           verdict_i,
  output logic               undef_o,
  output logic               trap_o,
  output logic [CLASS_W-1:0] trap_class_o,
  output logic               nop_o,
  output logic               exec_o,
  output logic               scope_excl_o
);

  logic [3:0]         flags_q, flags_d;
  logic [CLASS_W-1:0] class_q, class_d;
  logic               excl_q, excl_d;
  logic               load_en;

  // load on a strobe, or to clear a pulse left from the previous one
  assign load_en = valid_i || (|flags_q);

  always_comb begin
    flags_d = 4'b0000;
    class_d = '0;
    excl_d  = 1'b0;
    if (valid_i) begin
      unique case (verdict_i.kind)
        OUT_UNDEF: flags_d = 4'b0001;
        OUT_TRAP: begin
          flags_d = 4'b0010;
          class_d = TRAP_CLASS;
        end
        OUT_NOP:  flags_d = 4'b0100;
        OUT_EXEC: begin
          flags_d = 4'b1000;
          excl_d  = verdict_i.excl;
        end
        default:  flags_d = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= 4'b0000;
      class_q <= '0;
      excl_q  <= 1'b0;
    end else if (load_en) begin
      flags_q <= flags_d;
      class_q <= class_d;
      excl_q  <= excl_d;
    end
  end

  assign undef_o      = flags_q[0];
  assign trap_o       = flags_q[1];
  assign nop_o        = flags_q[2];
  assign exec_o       = flags_q[3];
  assign trap_class_o = class_q;
  assign scope_excl_o = excl_q;

endmodule

// File: rtl/sysop_access_decode.sv
module sysop_access_decode
  import sysop_pkg::*;
#(
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [OP0_W-1:0]   op0_i,
  input  logic [OP1_W-1:0]   op1_i,
  input  logic [CR_W-1:0]    crn_i,
  input  logic [CR_W-1:0]    crm_i,
  input  logic [OP2_W-1:0]   op2_i,
  input  logic [1:0]         cur_el_i,
  input  logic               nest_trap_i,
  input  logic               xs_feat_i,
  input  logic               instr_feat_i,
  input  logic               el2_en_i,
  input  logic               realm_feat_i,
  input  logic               sec_valid_i,
  output logic               undef_o,
  output logic               trap_o,
  output logic [CLASS_W-1:0] trap_class_o,
  output logic               nop_o,
  output logic               exec_o,
  output logic               scope_excl_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NFORMS-1:0] hit;
  verdict_t          verdict;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sysop_enc_match u_match (
    .op0_i (op0_i),
    .op1_i (op1_i),
    .crn_i (crn_i),
    .crm_i (crm_i),
    .op2_i (op2_i),
    .hit_o (hit)
  );

  sysop_priv_resolve u_resolve (
    .hit_i        (hit),
    .cur_el_i     (cur_el_i),
    .nest_trap_i  (nest_trap_i),
    .xs_feat_i    (xs_feat_i),
    .instr_feat_i (instr_feat_i),
    .el2_en_i     (el2_en_i),
    .realm_feat_i (realm_feat_i),
    .sec_valid_i  (sec_valid_i),
    .verdict_o    (verdict)
  );

  sysop_out_reg #(.TRAP_CLASS(TRAP_CLASS)) u_oreg (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .valid_i      (valid_i),
    .verdict_i    (verdict),
    .undef_o      (undef_o),
    .trap_o       (trap_o),
    .trap_class_o (trap_class_o),
    .nop_o        (nop_o),
    .exec_o       (exec_o),
    .scope_excl_o (scope_excl_o)
  );

endmodule

// File: rtl/sysop_access_decode_chk.sv
module sysop_access_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [1:0] op0_i,
  input logic [2:0] op1_i,
  input logic [3:0] crn_i,
  input logic [3:0] crm_i,
  input logic [2:0] op2_i,
  input logic [1:0] cur_el_i,
  input logic       nest_trap_i,
  input logic       xs_feat_i,
  input logic       instr_feat_i,
  input logic       undef_o,
  input logic       trap_o,
  input logic [5:0] trap_class_o,
  input logic       nop_o,
  input logic       exec_o,
  input logic       scope_excl_o
);

  logic base_ok, is_plain, is_excl;
  assign base_ok  = (op0_i == 2'b01) && (op1_i == 3'b100) &&
                    (crm_i == 4'b0010) && (op2_i == 3'b010);
  assign is_plain = base_ok && (crn_i == 4'b1000);
  assign is_excl  = base_ok && (crn_i == 4'b1001);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({undef_o, trap_o, nop_o, exec_o}) <= 1); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !(undef_o || trap_o || nop_o || exec_o)); // R10

  AST_NO_MATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !is_plain && !is_excl) |=> !(undef_o || trap_o || nop_o || exec_o)); // R1

  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_class_o == 6'h18)); // R6

  AST_CLASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> (trap_class_o == 6'h00)); // R6

  AST_EXCL_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    scope_excl_o |-> exec_o); // R2

  AST_NOFEAT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !instr_feat_i && (is_plain || is_excl)) |=> undef_o); // R3

  AST_NOXS_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !xs_feat_i && is_excl) |=> undef_o); // R4

  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (cur_el_i == 2'd0) && (is_plain || is_excl)) |=> undef_o); // R5

  AST_EL1_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (cur_el_i == 2'd1) && !nest_trap_i) |=> !trap_o); // R6

endmodule

bind sysop_access_decode sysop_access_decode_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .valid_i      (valid_i),
  .op0_i        (op0_i),
  .op1_i        (op1_i),
  .crn_i        (crn_i),
  .crm_i        (crm_i),
  .op2_i        (op2_i),
  .cur_el_i     (cur_el_i),
  .nest_trap_i  (nest_trap_i),
  .xs_feat_i    (xs_feat_i),
  .instr_feat_i (instr_feat_i),
  .undef_o      (undef_o),
  .trap_o       (trap_o),
  .trap_class_o (trap_class_o),
  .nop_o        (nop_o),
  .exec_o       (exec_o),
  .scope_excl_o (scope_excl_o)
);

// File: tb/sysop_access_decode_test.sv
`timescale 1ns/1ps
module sysop_access_decode_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid_i;
  logic [1:0] op0_i;
  logic [2:0] op1_i;
  logic [3:0] crn_i, crm_i;
  logic [2:0] op2_i;
  logic [1:0] cur_el_i;
  logic       nest_trap_i, xs_feat_i, instr_feat_i, el2_en_i, realm_feat_i, sec_valid_i;
  logic       undef_o, trap_o, nop_o, exec_o, scope_excl_o;
  logic [5:0] trap_class_o;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sysop_access_decode uut (.*);

  // vector: {form[1:0], el[1:0], nest, xsf, instr, el2en, realm, secv, exp u,t,n,e,x}
  // form 0 plain, 1 XS-excluding, 2 CRn=1010, 3 plain fields with op2=011
  localparam int NV = 20;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 2'd0, 6'b011101, 5'b10000},  // R5 EL0 plain
    {2'd0, 2'd1, 6'b111101, 5'b01000},  // R6 trap
    {2'd0, 2'd1, 6'b011101, 5'b10000},  // R6 no nest -> undef
    {2'd0, 2'd2, 6'b011101, 5'b00010},  // R7 plain exec all scope
    {2'd1, 2'd2, 6'b011101, 5'b00011},  // R2 R7 excl exec
    {2'd1, 2'd2, 6'b001101, 5'b10000},  // R4 no XS at EL2
    {2'd1, 2'd3, 6'b001001, 5'b10000},  // R4 priority over EL3 no-op
    {2'd1, 2'd1, 6'b101101, 5'b10000},  // R4 priority over trap
    {2'd0, 2'd3, 6'b011001, 5'b00100},  // R8 EL2 disabled
    {2'd0, 2'd3, 6'b011110, 5'b00100},  // R8 realm + invalid state
    {2'd0, 2'd3, 6'b011111, 5'b00010},  // R9 realm + valid
    {2'd0, 2'd3, 6'b011100, 5'b00010},  // R9 no realm, state ignored
    {2'd1, 2'd3, 6'b011100, 5'b00011},  // R9 excl scope at EL3
    {2'd0, 2'd2, 6'b010101, 5'b10000},  // R3 not implemented
    {2'd1, 2'd1, 6'b110101, 5'b10000},  // R3 over trap
    {2'd2, 2'd2, 6'b011101, 5'b00000},  // R1 wrong CRn
    {2'd3, 2'd3, 6'b011101, 5'b00000},  // R1 wrong op2
    {2'd0, 2'd2, 6'b001101, 5'b00010},  // R4 plain ignores XS
    {2'd1, 2'd3, 6'b011001, 5'b00100},  // R8 excl no-op
    {2'd1, 2'd1, 6'b111101, 5'b01000}   // R6 excl trap
  };

  task automatic set_form(input logic [1:0] f);
    op0_i = 2'b01; op1_i = 3'b100; crm_i = 4'b0010; op2_i = 3'b010;
    case (f)
      2'd0: crn_i = 4'b1000;
      2'd1: crn_i = 4'b1001;
      2'd2: crn_i = 4'b1010;
      default: begin crn_i = 4'b1000; op2_i = 3'b011; end
    endcase
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    logic [5:0] ecls;
    act  = {undef_o, trap_o, nop_o, exec_o, scope_excl_o};
    ecls = exp[3] ? 6'h18 : 6'h00;
    nvec++;
    if (act !== exp || trap_class_o !== ecls) begin
      nfail++;
      $display("FAIL %s: flags=%b class=%h expected flags=%b class=%h",
               req, act, trap_class_o, exp, ecls);
    end
  endtask

  task automatic apply(input logic [14:0] v, input string req);
    @(negedge clk);
    set_form(v[14:13]);
    cur_el_i = v[12:11];
    {nest_trap_i, xs_feat_i, instr_feat_i, el2_en_i, realm_feat_i, sec_valid_i} = v[10:5];
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, v[4:0]);
  endtask

  initial begin
    valid_i = 0; set_form(2'd0); cur_el_i = 0;
    {nest_trap_i, xs_feat_i, instr_feat_i, el2_en_i, realm_feat_i, sec_valid_i} = 6'b011101;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", 5'b00000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 after reset", 5'b00000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], $sformatf("vector %0d", i));
      @(negedge clk);
      check("R10 idle after strobe", 5'b00000);
    end

    // R10 back-to-back strobes: second result replaces first
    apply({2'd0, 2'd1, 6'b111101, 5'b01000}, "R6 b2b first");
    set_form(2'd1); cur_el_i = 2'd2; nest_trap_i = 0; valid_i = 1;
    @(negedge clk); valid_i = 0;
    check("R10 b2b second", 5'b00011);

    // R1 wrong op0 and wrong op1
    set_form(2'd0); op0_i = 2'b11; cur_el_i = 2'd2; valid_i = 1;
    @(negedge clk); valid_i = 0;
    check("R1 wrong op0", 5'b00000);
    set_form(2'd0); op1_i = 3'b000; valid_i = 1;
    @(negedge clk); valid_i = 0;
    check("R1 wrong op1", 5'b00000);

    // R11 reset mid pulse clears outputs
    set_form(2'd0); cur_el_i = 2'd2; valid_i = 1;
    @(negedge clk); valid_i = 0;
    check("R7 before reset", 5'b00010);
    #2 rst_n = 0;
    #1 check("R11 async clear", 5'b00000);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 after second reset", 5'b00000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule